// File: doc/BRIEF.md
# Sequence-Driven Core Power Controller

This block takes a processor core into a low-power mode and back out by running a small program of one-byte commands. The program sits in a local 128-entry command memory. Software loads it through a simple register port. Each supported low-power mode is its own command sequence, and software picks a mode only by writing that sequence's first index into the control register, together with an enable bit.

When the core raises its wait-for-interrupt indication and the controller is enabled and idle, the sequencer starts fetching commands at the programmed index. It runs one command per clock cycle:

- A power command drives a 4-bit power-control bus.
- A wait command parks the sequencer until a wake interrupt is seen. A wake that arrived earlier in the run is remembered.
- An end command finishes the exit. The controller passes through a one-cycle done state and returns to idle, releasing the core.

A status register shows the machine state and the current command index, so software can follow progress.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the controller is idle: status reads 0, the control register reads 0, `pwr_ctl` is 0 and `core_sleep` is 0.
- R2: Address 0x00 is the control register. Bit 0 is the enable and bits 10:4 are the start index. Reads return only these fields; all other bits read as 0.
- R3: While the enable bit is clear, `core_wfi` is ignored and the controller stays idle.
- R4: When `core_wfi` is high, the controller is idle and the enable bit is set, the controller enters RUN on the next clock edge with its command index equal to the start index. Address 0x01 is the status register, with state in bits 1:0 (IDLE=0, RUN=1, WAIT=2, DONE=3) and the current index in bits 10:4.
- R5: Writing address 0x80+i stores byte i of the command memory. In RUN, a command with bit 7 clear loads its bits 3:0 into `pwr_ctl` and advances the index by one, one command per cycle.
- R6: Command 0xFE (wait for wake) with no wake seen moves the controller to WAIT. There the index and `pwr_ctl` hold until `wake_irq` is high, and on that edge execution resumes in RUN at the next index.
- R7: A `wake_irq` pulse seen earlier in the same run satisfies a later 0xFE at once: the controller goes on to the next index without entering WAIT.
- R8: Command 0xFF (end) moves the controller to DONE for exactly one cycle and then to IDLE, with the index unchanged. `core_sleep` is high only in RUN and WAIT.
- R9: Execution past index 127 wraps to index 0.
- R10: `core_wfi` while a sequence is running or waiting does not restart it or change its index.
- R11: Any other command with bit 7 set is a no-op: `pwr_ctl` is kept and the index advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address (0x00 control, 0x01 status, 0x80-0xFF command memory) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| core_wfi | input | 1 | Wait-for-interrupt indication from the core |
| wake_irq | input | 1 | Wake interrupt |
| pwr_ctl | output | 4 | Power-control outputs set by commands |
| core_sleep | output | 1 | High while a sequence is active (RUN or WAIT) |

## Verification
The bench runs three full sequences and compares every cycle's status word and power outputs against indices stepped forward in the bench.

- **Wrap at the top of memory.** A design that fails to wrap would run into missing bytes or stop early.
- **No-op byte.** A design that decodes the no-op as a power command would corrupt `pwr_ctl`.
- **Wake that arrives before the wait command.** A design that forgets such a wake would park in WAIT forever.
- **Stray `core_wfi` during WAIT.** A design that restarts on it would jump back to the start index.
- **Disabled controller.** A design that ignores the enable bit would start a sequence.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } seq_state_t;

  localparam logic [7:0] CMD_END  = 8'hFF;
  localparam logic [7:0] CMD_WAIT = 8'hFE;
  localparam int         CMD_W    = 8;
  localparam int         FIELD_LO = 4;
endpackage

// File: rtl/pwr_cmd_mem.sv
module pwr_cmd_mem #(
  parameter int IDX_W = 7,
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CMD_W-1:0] wr_byte,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CMD_W-1:0] rd_byte
);
  localparam int DEPTH = 1 << IDX_W;

  logic [CMD_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store_q[wr_idx] <= wr_byte;
    end
  end

  assign rd_byte = store_q[rd_idx];
endmodule

// File: rtl/pwr_ctrl_regs.sv
module pwr_ctrl_regs
  import pwr_seq_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  seq_state_t        stat_state,
  input  logic [IDX_W-1:0]  stat_idx,
  output logic              ctl_en,
  output logic [IDX_W-1:0]  ctl_start,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_idx,
  output logic [CMD_W-1:0]  mem_byte
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);

  logic             en_q, en_d;
  logic [IDX_W-1:0] start_q, start_d;
  logic             ctrl_wr;
  logic             mem_sel;

  assign ctrl_wr = reg_we && (reg_addr == A_CTRL);
  assign mem_sel = reg_addr[ADDR_W-1];

  always_comb begin
    en_d    = en_q;
    start_d = start_q;
    if (ctrl_wr) begin
      en_d    = reg_wdata[0];
      start_d = reg_wdata[FIELD_LO +: IDX_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      start_q <= '0;
    end else begin
      en_q    <= en_d;
      start_q <= start_d;
    end
  end

  assign ctl_en    = en_q;
  assign ctl_start = start_q;
  assign mem_we    = reg_we && mem_sel;
  assign mem_idx   = reg_addr[IDX_W-1:0];
  assign mem_byte  = reg_wdata[CMD_W-1:0];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) begin
      reg_rdata[0]                  = en_q;
      reg_rdata[FIELD_LO +: IDX_W]  = start_q;
    end else if (reg_addr == A_STAT) begin
      reg_rdata[1:0]                = stat_state;
      reg_rdata[FIELD_LO +: IDX_W]  = stat_idx;
    end
  end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int PWR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [IDX_W-1:0] start_idx,
  input  logic             core_wfi,
  input  logic             wake_irq,
  input  logic [CMD_W-1:0] cmd,
  output logic [IDX_W-1:0] idx,
  output seq_state_t       state,
  output logic [PWR_W-1:0] pwr,
  output logic             sleep
);
  seq_state_t       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [PWR_W-1:0] pwr_q, pwr_d;
  logic             pend_q, pend_d;
  logic             wake_seen;
  logic [IDX_W-1:0] idx_inc;

  assign wake_seen = wake_irq | pend_q;
  assign idx_inc   = idx_q + IDX_W'(1);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    pwr_d  = pwr_q;
    pend_d = pend_q;
    if ((st_q != ST_IDLE) && wake_irq) pend_d = 1'b1;
    case (st_q)
      ST_IDLE: begin
        if (en && core_wfi) begin
          st_d   = ST_RUN;
          idx_d  = start_idx;
          pend_d = 1'b0;
        end
      end
      ST_RUN: begin
        if (cmd == CMD_END) begin
          st_d = ST_DONE;
        end else if (cmd == CMD_WAIT) begin
          if (wake_seen) begin
            idx_d  = idx_inc;
            pend_d = 1'b0;
          end else begin
            st_d = ST_WAIT;
          end
        end else begin
          if (!cmd[CMD_W-1]) pwr_d = cmd[PWR_W-1:0];
          idx_d = idx_inc;
        end
      end
      ST_WAIT: begin
        if (wake_seen) begin
          st_d   = ST_RUN;
          idx_d  = idx_inc;
          pend_d = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      pwr_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      pwr_q  <= pwr_d;
      pend_q <= pend_d;
    end
  end

  assign idx   = idx_q;
  assign state = st_q;
  assign pwr   = pwr_q;
  assign sleep = (st_q == ST_RUN) || (st_q == ST_WAIT);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !en) |=> (st_q == ST_IDLE));

  assert_start_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && en && core_wfi) |=> (st_q == ST_RUN && idx_q == $past(start_idx)));

  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !wake_irq && !pend_q) |=>
      (st_q == ST_WAIT && $stable(idx_q) && $stable(pwr_q)));

  assert_end_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && cmd == CMD_END) |=> (st_q == ST_DONE && $stable(idx_q)));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |=> (st_q == ST_IDLE));

  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && idx_q == '1 && cmd != CMD_END && cmd != CMD_WAIT) |=> (idx_q == '0));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int PWR_W  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              core_wfi,
  input  logic              wake_irq,
  output logic [PWR_W-1:0]  pwr_ctl,
  output logic              core_sleep
);
  logic             ctl_en;
  logic [IDX_W-1:0] ctl_start;
  logic             mem_we;
  logic [IDX_W-1:0] mem_idx;
  logic [CMD_W-1:0] mem_byte;
  logic [IDX_W-1:0] cur_idx;
  logic [CMD_W-1:0] cur_cmd;
  seq_state_t       cur_state;

  pwr_ctrl_regs #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stat_state(cur_state), .stat_idx(cur_idx),
    .ctl_en(ctl_en), .ctl_start(ctl_start),
    .mem_we(mem_we), .mem_idx(mem_idx), .mem_byte(mem_byte)
  );

  pwr_cmd_mem #(.IDX_W(IDX_W), .CMD_W(CMD_W)) u_mem (
    .clk(clk), .wr_en(mem_we), .wr_idx(mem_idx), .wr_byte(mem_byte),
    .rd_idx(cur_idx), .rd_byte(cur_cmd)
  );

  pwr_seq_fsm #(.IDX_W(IDX_W), .PWR_W(PWR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .start_idx(ctl_start),
    .core_wfi(core_wfi), .wake_irq(wake_irq), .cmd(cur_cmd),
    .idx(cur_idx), .state(cur_state), .pwr(pwr_ctl), .sleep(core_sleep)
  );
endmodule

// File: tb/pwr_seq_ctrl_bench.sv
module pwr_seq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h01;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        core_wfi = 1'b0;
  logic        wake_irq = 1'b0;
  logic [3:0]  pwr_ctl;
  logic        core_sleep;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_ctrl u_pwr_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_wfi(core_wfi),
    .wake_irq(wake_irq), .pwr_ctl(pwr_ctl), .core_sleep(core_sleep)
  );

  function automatic logic [31:0] stat(input int idx, input int st);
    return 32'((idx % 128) << 4) | 32'(st);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 8'h01;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 status", reg_rdata, 32'h0);
    chk("R1 pwr", 32'(pwr_ctl), 32'h0);
    chk("R1 sleep", 32'(core_sleep), 32'h0);
    reg_addr = 8'h00; #1;
    chk("R1 ctrl", reg_rdata, 32'h0);
    reg_addr = 8'h01;

    // R2 field masking
    wr(8'h00, 32'hFFFF_FFFF);
    reg_addr = 8'h00; #1;
    chk("R2 ctrl readback", reg_rdata, 32'h7F1);
    reg_addr = 8'h01;

    // R3 disabled: wfi ignored
    wr(8'h00, 32'h0A0);
    core_wfi = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R3 stays idle", reg_rdata, stat(0, 0));
      chk("R3 no sleep", 32'(core_sleep), 32'h0);
    end
    core_wfi = 1'b0;

    // program sequence A at 10
    wr(8'h80 | 8'd10, 32'h05);
    wr(8'h80 | 8'd11, 32'h0A);
    wr(8'h80 | 8'd12, 32'hFE);
    wr(8'h80 | 8'd13, 32'h03);
    wr(8'h80 | 8'd14, 32'hFF);
    wr(8'h00, 32'h0A1);
    core_wfi = 1'b1;
    step(); core_wfi = 1'b0;
    chk("R4 start index", reg_rdata, stat(10, 1));
    chk("R8 sleep in run", 32'(core_sleep), 32'h1);
    step();
    chk("R5 idx 11", reg_rdata, stat(11, 1));
    chk("R5 pwr 5", 32'(pwr_ctl), 32'h5);
    step();
    chk("R5 idx 12", reg_rdata, stat(12, 1));
    chk("R5 pwr A", 32'(pwr_ctl), 32'hA);
    step();
    chk("R6 enter wait", reg_rdata, stat(12, 2));
    core_wfi = 1'b1;
    step(); core_wfi = 1'b0;
    chk("R10 wfi in wait ignored", reg_rdata, stat(12, 2));
    step();
    chk("R6 still waiting", reg_rdata, stat(12, 2));
    chk("R6 pwr held", 32'(pwr_ctl), 32'hA);
    chk("R8 sleep in wait", 32'(core_sleep), 32'h1);
    wake_irq = 1'b1;
    step(); wake_irq = 1'b0;
    chk("R6 resume", reg_rdata, stat(13, 1));
    step();
    chk("R5 idx 14", reg_rdata, stat(14, 1));
    chk("R5 pwr 3", 32'(pwr_ctl), 32'h3);
    step();
    chk("R8 done", reg_rdata, stat(14, 3));
    chk("R8 sleep low", 32'(core_sleep), 32'h0);
    step();
    chk("R8 idle", reg_rdata, stat(14, 0));
    chk("R8 pwr kept", 32'(pwr_ctl), 32'h3);

    // sequence B at 20: early wake
    wr(8'h80 | 8'd20, 32'h07);
    wr(8'h80 | 8'd21, 32'hFE);
    wr(8'h80 | 8'd22, 32'hFF);
    wr(8'h00, 32'h141);
    core_wfi = 1'b1;
    step(); core_wfi = 1'b0;
    chk("R4 start 20", reg_rdata, stat(20, 1));
    wake_irq = 1'b1;
    step(); wake_irq = 1'b0;
    chk("R7 idx 21", reg_rdata, stat(21, 1));
    chk("R7 pwr 7", 32'(pwr_ctl), 32'h7);
    step();
    chk("R7 no wait state", reg_rdata, stat(22, 1));
    step();
    chk("R7 done", reg_rdata, stat(22, 3));
    step();
    chk("R7 idle", reg_rdata, stat(22, 0));

    // sequence C at 126: no-op and wrap
    wr(8'h80 | 8'd126, 32'h01);
    wr(8'h80 | 8'd127, 32'h80);
    wr(8'h80 | 8'd0,   32'h02);
    wr(8'h80 | 8'd1,   32'hFF);
    wr(8'h00, 32'h7E1);
    core_wfi = 1'b1;
    step(); core_wfi = 1'b0;
    chk("R4 start 126", reg_rdata, stat(126, 1));
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R9 index steps", reg_rdata, stat(127 + k, 1));
      chk("R11 pwr value", 32'(pwr_ctl), (k == 2) ? 32'h2 : 32'h1);
    end
    step();
    chk("R9 done after wrap", reg_rdata, stat(1, 3));
    step();
    chk("R9 idle", reg_rdata, stat(1, 0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule